// File: doc/BRIEF.md
# Signalling Bit Frame Extractor

The block sits behind the carrier-voting and differential-decoding stages of an OFDM receiver. It takes one decided signalling bit per OFDM symbol, qualified by a symbol strobe. It searches the bit stream for the frame synchronisation word. Once it has found a frame it counts symbols to locate each later frame boundary, and it checks that the sync word flips polarity from one frame to the next. It also keeps track of where the current frame sits inside a superframe of four frames.

At the end of every frame whose sync word checks out while aligned, the block publishes the transmission parameters carried in that frame as register fields and raises a one-cycle valid pulse. The published fields are length indicator, constellation, hierarchy, both code rates, guard ratio, mode and frame number. The 16-bit cell identifier arrives one byte per frame, so the block rebuilds it across an even frame and an odd frame. Error correction of the frame is left to other logic.

Top module: `tps_frame_extractor`

## Requirements
- R1: While and after a synchronous reset (`rst` high), `locked`, `params_valid`, `cell_valid`, `frame_num`, `cell_id` and every parameter field read zero.
- R2: Frame bit k is the k-th strobed bit of a 68-bit frame. Bits 1..16 hold the sync word with bit 1 as MSB, either 0x35EE or its inverse 0xCA11. `locked` rises the cycle after the strobe of bit 67 of the second consecutive frame whose sync word is the inverse of the previous one. After one such frame alone, `locked` stays low.
- R3: While locked, a single frame with a wrong sync word leaves `locked` high. A second consecutive wrong frame clears `locked`, and the block returns to searching.
- R4: `params_valid` pulses for exactly one cycle, the cycle after the last bit of a frame that passed the sync check while aligned. Fields change only together with that pulse, and a failed frame leaves them unchanged.
- R5: All fields are read MSB first, starting at the lowest frame bit of each field:
  - `length_ind` = bits 17..22
  - `constellation` = 25..26
  - `hierarchy` = 27..29
  - `hp_rate` = 30..32
  - `lp_rate` = 33..35
  - `guard` = 36..37
  - `mode` = 38..39
  - cell byte = 40..47
- R6: On acquisition the frame-number field (bits 23..24, bit 23 MSB) of the acquired frame is taken as its index. Each later frame end, good or bad, advances the index modulo 4. `frame_num` shows the index of the frame just published.
- R7: The cell byte of a frame with an even index goes to `cell_id[15:8]`, and that of an odd frame to `cell_id[7:0]`. `cell_valid` is high once both halves have been received since the last acquisition. It falls when lock is lost.
- R8: After each frame end the expected sync polarity toggles, also across a failed frame. A frame repeating the previous frame's polarity counts as a failure.
- R9: While searching, the block acquires a frame at any bit offset. It does so at the strobe that completes a 68-bit window carrying either sync polarity in bits 1..16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_stb | input | 1 | One pulse per OFDM symbol |
| sym_bit | input | 1 | Decided signalling bit, qualified by sym_stb |
| locked | output | 1 | Frame lock |
| params_valid | output | 1 | One-cycle pulse when fields update |
| frame_num | output | 2 | Index of the published frame in the superframe |
| length_ind | output | 6 | Length indicator |
| constellation | output | 2 | Constellation code |
| hierarchy | output | 3 | Hierarchy code |
| hp_rate | output | 3 | High-priority code rate |
| lp_rate | output | 3 | Low-priority code rate |
| guard | output | 2 | Guard ratio code |
| mode | output | 2 | Transmission mode code |
| cell_id | output | 16 | Rebuilt cell identifier |
| cell_valid | output | 1 | Both cell identifier halves present |

## Verification
The assertions assume that symbol strobes are sparse enough that two frame ends never fall on adjacent cycles, which always holds because a frame spans 68 strobes. They also assume that bits outside a strobe carry no meaning. The stimulus strobes every other cycle and holds `sym_bit` steady around each strobe. The frame payloads are chosen so that no shifted window of data bits reproduces either sync polarity. This way, searching after a start offset or after a loss of lock can only hit a real frame boundary.

// File: rtl/tps_frame_extractor.sv
module tps_frame_extractor #(
  parameter int          FRAME_BITS = 68,
  parameter logic [15:0] SYNC_WORD  = 16'h35EE
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sym_stb,
  input  logic        sym_bit,
  output logic        locked,
  output logic        params_valid,
  output logic [1:0]  frame_num,
  output logic [5:0]  length_ind,
  output logic [1:0]  constellation,
  output logic [2:0]  hierarchy,
  output logic [2:0]  hp_rate,
  output logic [2:0]  lp_rate,
  output logic [1:0]  guard,
  output logic [1:0]  mode,
  output logic [15:0] cell_id,
  output logic        cell_valid
);
  localparam int TOP = FRAME_BITS - 1;
  localparam int CW  = $clog2(FRAME_BITS);
  localparam logic [CW-1:0] LAST = CW'(FRAME_BITS - 1);

  logic [TOP:0] sr, nxt, rev;
  logic [CW-1:0] cnt;
  logic aligned, exp_inv, fail1, got_hi, got_lo;
  logic [1:0] fidx;

  assign nxt = {sym_bit, sr[TOP:1]};
  always_comb
    for (int i = 0; i < FRAME_BITS; i++) rev[TOP-i] = nxt[i];

  wire [15:0] rx_sync   = rev[TOP-1  -: 16];
  wire [1:0]  rx_fn     = rev[TOP-23 -: 2];
  wire        either    = (rx_sync == SYNC_WORD) || (rx_sync == ~SYNC_WORD);
  wire        hunt_hit  = sym_stb && !aligned && either;
  wire        frame_end = sym_stb && aligned && (cnt == LAST);
  wire        sync_ok   = rx_sync == (exp_inv ? ~SYNC_WORD : SYNC_WORD);

  assign cell_valid = got_hi && got_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr <= '0; cnt <= '0; aligned <= 1'b0; exp_inv <= 1'b0; fail1 <= 1'b0;
      fidx <= '0; got_hi <= 1'b0; got_lo <= 1'b0; locked <= 1'b0;
      params_valid <= 1'b0; frame_num <= '0; length_ind <= '0;
      constellation <= '0; hierarchy <= '0; hp_rate <= '0; lp_rate <= '0;
      guard <= '0; mode <= '0; cell_id <= '0;
    end else begin
      params_valid <= 1'b0;
      if (sym_stb) sr <= nxt;
      if (hunt_hit) begin
        aligned <= 1'b1;
        cnt     <= '0;
        exp_inv <= (rx_sync == SYNC_WORD);
        fidx    <= rx_fn + 2'd1;
        fail1   <= 1'b0;
      end else if (sym_stb && aligned) begin
        cnt <= frame_end ? '0 : cnt + 1'b1;
      end
      if (frame_end) begin
        exp_inv <= ~exp_inv;
        fidx    <= fidx + 2'd1;
        if (sync_ok) begin
          locked        <= 1'b1;
          fail1         <= 1'b0;
          params_valid  <= 1'b1;
          frame_num     <= fidx;
          length_ind    <= rev[TOP-17 -: 6];
          constellation <= rev[TOP-25 -: 2];
          hierarchy     <= rev[TOP-27 -: 3];
          hp_rate       <= rev[TOP-30 -: 3];
          lp_rate       <= rev[TOP-33 -: 3];
          guard         <= rev[TOP-36 -: 2];
          mode          <= rev[TOP-38 -: 2];
          if (fidx[0]) begin
            cell_id[7:0] <= rev[TOP-40 -: 8];
            got_lo <= 1'b1;
          end else begin
            cell_id[15:8] <= rev[TOP-40 -: 8];
            got_hi <= 1'b1;
          end
        end else if (locked && !fail1) begin
          fail1 <= 1'b1;
        end else begin
          aligned <= 1'b0; locked <= 1'b0; fail1 <= 1'b0;
          got_hi <= 1'b0; got_lo <= 1'b0;
        end
      end
    end
  end

  p_pub_locked_r4: assert property (@(posedge clk) disable iff (rst)
    params_valid |-> locked);
  p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    params_valid |=> !params_valid);
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !params_valid |-> ($stable(mode) && $stable(cell_id) && $stable(frame_num)));
  p_lock_pub_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> params_valid);
  p_cell_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(cell_valid) |-> params_valid);
  p_unlock_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(locked) |-> (!cell_valid && !aligned));
endmodule

// File: tb/sim_tps_frame_extractor.sv
`timescale 1ns/1ps
module sim_tps_frame_extractor;
  logic clk = 1'b0, rst = 1'b1, sym_stb = 1'b0, sym_bit = 1'b0;
  logic locked, params_valid, cell_valid;
  logic [1:0] frame_num, constellation, guard, mode;
  logic [5:0] length_ind;
  logic [2:0] hierarchy, hp_rate, lp_rate;
  logic [15:0] cell_id;

  always #2 clk = ~clk;

  tps_frame_extractor u0 (.*);

  typedef struct packed {
    logic [1:0] fn; logic [5:0] len; logic [1:0] con; logic [2:0] hier;
    logic [2:0] hp; logic [2:0] lp; logic [1:0] gd; logic [1:0] md;
    logic [15:0] cid; logic cv;
  } pub_t;

  pub_t q[$];
  int total = 0, bad = 0;
  bit done = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [67:0] build(input logic [15:0] sw, input logic [1:0] fn,
      input logic [5:0] len, input logic [1:0] con, input logic [2:0] hier,
      input logic [2:0] hp, input logic [2:0] lp, input logic [1:0] gd,
      input logic [1:0] md, input logic [7:0] cb);
    logic [67:0] f = '0;
    for (int i = 0; i < 16; i++) f[1+i]  = sw[15-i];
    for (int i = 0; i < 6; i++)  f[17+i] = len[5-i];
    for (int i = 0; i < 2; i++)  f[23+i] = fn[1-i];
    for (int i = 0; i < 2; i++)  f[25+i] = con[1-i];
    for (int i = 0; i < 3; i++)  f[27+i] = hier[2-i];
    for (int i = 0; i < 3; i++)  f[30+i] = hp[2-i];
    for (int i = 0; i < 3; i++)  f[33+i] = lp[2-i];
    for (int i = 0; i < 2; i++)  f[36+i] = gd[1-i];
    for (int i = 0; i < 2; i++)  f[38+i] = md[1-i];
    for (int i = 0; i < 8; i++)  f[40+i] = cb[7-i];
    for (int i = 0; i < 14; i++) f[54+i] = i[0];
    return f;
  endfunction

  task automatic send_bit(input logic b);
    @(negedge clk); sym_stb = 1'b1; sym_bit = b;
    @(negedge clk); sym_stb = 1'b0;
  endtask

  task automatic send_frame(input logic [67:0] f);
    for (int k = 0; k < 68; k++) send_bit(f[k]);
  endtask

  always @(negedge clk) begin
    if (!rst && params_valid) begin
      pub_t act, exp;
      act = '{frame_num, length_ind, constellation, hierarchy, hp_rate, lp_rate,
              guard, mode, cell_id, cell_valid};
      total++;
      if (q.size() == 0) begin
        bad++;
        $display("FAIL R4 unexpected publish actual=%h expected=none", act);
      end else begin
        exp = q.pop_front();
        if (act !== exp) begin
          bad++;
          $display("FAIL R5 R6 R7 publish actual=%h expected=%h", act, exp);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 locked", locked, 0);
    check("R1 fields", {params_valid, frame_num, length_ind, mode, cell_id, cell_valid}, 0);
    rst = 1'b0;
    send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    // R9 acquisition after an offset; R2 one frame is not enough
    send_frame(build(16'h35EE, 2'd0, 6'h17, 2'd2, 3'd1, 3'd3, 3'd1, 2'd2, 2'd1, 8'hA5));
    check("R2 after one frame", locked, 0);
    q.push_back('{2'd1, 6'h05, 2'd1, 3'd0, 3'd2, 3'd4, 2'd3, 2'd0, 16'h003C, 1'b0});
    send_frame(build(16'hCA11, 2'd1, 6'h05, 2'd1, 3'd0, 3'd2, 3'd4, 2'd3, 2'd0, 8'h3C));
    check("R2 locked", locked, 1);
    q.push_back('{2'd2, 6'h20, 2'd2, 3'd3, 3'd1, 3'd0, 2'd1, 2'd2, 16'h813C, 1'b1});
    send_frame(build(16'h35EE, 2'd2, 6'h20, 2'd2, 3'd3, 3'd1, 3'd0, 2'd1, 2'd2, 8'h81));
    check("R7 cell_valid", cell_valid, 1);
    q.push_back('{2'd3, 6'h11, 2'd0, 3'd2, 3'd4, 3'd2, 2'd0, 2'd3, 16'h817E, 1'b1});
    send_frame(build(16'hCA11, 2'd3, 6'h11, 2'd0, 3'd2, 3'd4, 3'd2, 2'd0, 2'd3, 8'h7E));
    // R3 one bad frame keeps lock; R4 fields hold
    send_frame(build(16'h0000, 2'd0, 6'h00, 2'd1, 3'd1, 3'd1, 3'd1, 2'd1, 2'd1, 8'h00));
    check("R3 one failure", locked, 1);
    check("R4 fields held", {mode, length_ind, cell_id}, {2'd3, 6'h11, 16'h817E});
    // R6 index advanced across the failed frame; R8 polarity toggled
    q.push_back('{2'd1, 6'h09, 2'd3, 3'd1, 3'd1, 3'd3, 2'd2, 2'd1, 16'h8142, 1'b1});
    send_frame(build(16'hCA11, 2'd1, 6'h09, 2'd3, 3'd1, 3'd1, 3'd3, 2'd2, 2'd1, 8'h42));
    check("R8 locked before repeat", locked, 1);
    // R8 repeated polarity fails
    send_frame(build(16'hCA11, 2'd2, 6'h01, 2'd0, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 8'h11));
    check("R8 repeat is failure", locked, 1);
    check("R8 no update", mode, 2'd1);
    send_frame(build(16'h35EE, 2'd3, 6'h01, 2'd0, 3'd0, 3'd0, 3'd0, 2'd0, 2'd0, 8'h11));
    check("R3 two failures", locked, 0);
    check("R7 cell_valid cleared", cell_valid, 0);
    // R9 reacquire
    send_frame(build(16'h35EE, 2'd2, 6'h02, 2'd1, 3'd1, 3'd1, 3'd1, 2'd1, 2'd1, 8'h55));
    check("R9 searching", locked, 0);
    q.push_back('{2'd3, 6'h3F, 2'd2, 3'd2, 3'd2, 3'd2, 2'd2, 2'd2, 16'h81C3, 1'b0});
    send_frame(build(16'hCA11, 2'd3, 6'h3F, 2'd2, 3'd2, 3'd2, 3'd2, 2'd2, 2'd2, 8'hC3));
    check("R9 relocked", locked, 1);
    repeat (4) @(negedge clk);
    check("R4 all publishes seen", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule